// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single line. It sits behind a holding register: a write places a word in the holding register, and the word moves into the frame shift register on the next bit tick once the shifter is free and transmission is enabled. The frame format sets the data width (seven, eight or nine bits) and whether a parity bit follows the data. The parity sense is also selectable. The format, the parity sense and the buffering mode are all sampled when a word enters the shifter, so a frame already on the line keeps the settings it started with.

A mode input chooses between single and double buffering. With single buffering, a new word is taken only when the transmitter is completely idle, and the interrupt pulses as the stop bit starts. With double buffering, a word can be written while a frame is on the line. It is then sent directly after the current stop bit, with no idle gap, and the interrupt pulses when the holding register empties into the shifter, which is the same cycle the start bit begins. Bit timing comes from an external one-cycle tick, with one tick per bit period. Baud rate generation and register access are handled elsewhere.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, and at any time `busy` is low, `txd` is high and `tx_irq` is low.
- R2: A frame is one low start bit, then the data bits LSB first, then the optional parity bit, then one high stop bit. A frame starts only in the cycle after a `baud_tick`, and every bit lasts exactly from one `baud_tick` to the next.
- R3: `fmt_sel` encodes the format as follows: 0 = 7 data bits, 1 = 7 data bits plus parity, 2 = 8 data bits, 3 = 8 data bits plus parity, 4 = 9 data bits, and any other value = 8 data bits. The data bits are taken from the low bits of `wr_data`.
- R4: When present, the parity bit is the last bit before the stop bit. It gives even parity over the data bits when `par_odd` is 0 and odd parity when `par_odd` is 1.
- R5: `fmt_sel`, `par_odd` and `dbl_buf` are sampled when a word enters the shifter. Changing them during a frame has no effect on that frame.
- R6: In single-buffer mode, `tx_irq` is a one-cycle pulse in the first cycle of the stop bit. It does not pulse at the start bit.
- R7: In double-buffer mode, `tx_irq` is a one-cycle pulse in the first cycle of the start bit, which is the cycle right after the holding register empties into the shifter.
- R8: In double-buffer mode, a word accepted during a frame is sent back to back. Its start bit begins in the cycle after the last cycle of the previous stop bit.
- R9: A write is ignored in single-buffer mode while `busy` is high, and in double-buffer mode while the holding register is full. An ignored write produces no frame.
- R10: A held word is not sent while `tx_en` is low. Clearing `tx_en` during a frame does not cut the frame short.
- R11: `busy` is high from the cycle after a write is accepted until the stop bit of the last frame ends. It stays high while the shifter is active or the holding register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Allows a held word to enter the shifter |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | MAX_DATA_W | Word to send, LSB first |
| fmt_sel | input | 3 | Frame format select (see R3) |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| dbl_buf | input | 1 | 1 selects double-buffer mode |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Transmitter holds or is sending data |
| tx_irq | output | 1 | Transmit interrupt pulse |

## Verification
The bench concentrates on where each frame and interrupt begins. It runs every format with both parity senses; a parity bit placed after the stop bit or computed with the wrong sense shows up as a mismatching bit in the captured frame. Back-to-back frames in double-buffer mode are timed to the exact cycle, so a design that inserts an idle bit between frames, or that fires its interrupt at the stop bit in this mode, fails the gap check or the interrupt check. The bench also writes while a frame is in flight, changes the format in mid-frame, and drops the enable during a frame. A design that accepts the extra write, reformats the running frame or aborts on the enable produces an unexpected frame or a truncated one.

// File: rtl/uart_tx_pkg.sv
// Package: shared format encoding and decode for the serial transmitter.
// Assumes: formats never carry more than nine data bits.
package uart_tx_pkg;

    typedef enum logic [2:0] {
        FMT_D7   = 3'd0,
        FMT_D7P  = 3'd1,
        FMT_D8   = 3'd2,
        FMT_D8P  = 3'd3,
        FMT_D9   = 3'd4
    } fmt_e;

    typedef struct packed {
        logic [3:0] ndata;
        logic       par_en;
    } fmt_info_t;

    // Map the format select to data width and parity presence.
    function automatic fmt_info_t decode_fmt(input logic [2:0] sel);
        fmt_info_t r;
        case (sel)
            FMT_D7:  r = '{ndata: 4'd7, par_en: 1'b0};
            FMT_D7P: r = '{ndata: 4'd7, par_en: 1'b1};
            FMT_D8:  r = '{ndata: 4'd8, par_en: 1'b0};
            FMT_D8P: r = '{ndata: 4'd8, par_en: 1'b1};
            FMT_D9:  r = '{ndata: 4'd9, par_en: 1'b0};
            default: r = '{ndata: 4'd8, par_en: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tx_hold_buf.sv
// Module: holding register in front of the frame shifter.
// Accepts a word when it is empty and the caller allows it.
// Empties when the shifter takes the word.
// Assumes: take is only raised while full.
module tx_hold_buf #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         accept_ok,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);

    logic accept;

    // Decide whether this cycle's write is captured.
    always_comb begin
        accept = wr_valid && !full && accept_ok;
    end

    // Track occupancy and capture the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (accept) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_frame_engine.sv
// Module: frame builder and shifter.
// On a bit tick with a word pending and the shifter free, or finishing its
// stop bit, it latches format and mode, builds the frame and drives the
// start bit. Each later tick moves one bit onto the line.
// Assumes: baud_tick is a single-cycle pulse, one per bit period.
module tx_frame_engine
    import uart_tx_pkg::*;
#(
    parameter int MAX_DATA_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  baud_tick,
    input  logic                  pend,
    input  logic [MAX_DATA_W-1:0] word,
    input  logic [2:0]            fmt_sel,
    input  logic                  par_odd,
    input  logic                  dbl_buf,
    output logic                  txd,
    output logic                  active,
    output logic                  load_fire,
    output logic                  stop_begin,
    output logic                  dbl_q
);

    localparam int FRAME_W = MAX_DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   left;
    logic [CNT_W-1:0]   total;
    fmt_info_t          info;
    logic               par_bit;

    // Decode the format and assemble data, parity and stop into one vector.
    always_comb begin
        info    = decode_fmt(fmt_sel);
        frame   = '1;
        par_bit = par_odd;
        for (int i = 0; i < MAX_DATA_W; i++) begin
            if (i < int'(info.ndata)) begin
                frame[i] = word[i];
                par_bit  = par_bit ^ word[i];
            end
        end
        if (info.par_en) begin
            frame[info.ndata] = par_bit;
        end
        total = CNT_W'(info.ndata) + CNT_W'(info.par_en) + CNT_W'(1);
    end

    // Load on a tick when the line is free or the stop bit is ending.
    always_comb begin
        load_fire  = baud_tick && pend && (!active || (left == '0));
        stop_begin = baud_tick && active && (left == CNT_W'(1));
    end

    // Shift bits out one per tick and end the frame after the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left   <= '0;
            shreg  <= '1;
            txd    <= 1'b1;
            dbl_q  <= 1'b0;
        end else if (load_fire) begin
            active <= 1'b1;
            left   <= total;
            shreg  <= frame;
            txd    <= 1'b0;
            dbl_q  <= dbl_buf;
        end else if (baud_tick && active) begin
            if (left != '0) begin
                txd   <= shreg[0];
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - CNT_W'(1);
            end else begin
                active <= 1'b0;
                txd    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tx_irq_ctl.sv
// Module: interrupt point selection.
// Pulses at the load in double-buffer mode, or at the stop bit of a
// single-buffer frame. The pulse lines up with the first cycle of that bit.
// Assumes: the two events never fall in the same cycle.
module tx_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic load_fire,
    input  logic stop_begin,
    input  logic dbl_now,
    input  logic dbl_frame,
    output logic irq
);

    // Register the selected event as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (load_fire && dbl_now) || (stop_begin && !dbl_frame);
        end
    end

endmodule

// File: rtl/uart_dbuf_tx.sv
// Module: top of the double-buffered serial transmitter.
// Connects the holding register, the frame engine and the interrupt select.
// Assumes: bit timing comes from baud_tick, and the register bus is external.
module uart_dbuf_tx
    import uart_tx_pkg::*;
#(
    parameter int MAX_DATA_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  baud_tick,
    input  logic                  tx_en,
    input  logic                  wr_valid,
    input  logic [MAX_DATA_W-1:0] wr_data,
    input  logic [2:0]            fmt_sel,
    input  logic                  par_odd,
    input  logic                  dbl_buf,
    output logic                  txd,
    output logic                  busy,
    output logic                  tx_irq
);

    logic                  hold_full;
    logic [MAX_DATA_W-1:0] hold_data;
    logic                  load_fire;
    logic                  stop_begin;
    logic                  eng_active;
    logic                  eng_dbl;
    logic                  accept_ok;
    logic                  pend;

    // Single-buffer mode accepts writes only when the shifter is idle.
    always_comb begin
        accept_ok = dbl_buf || !eng_active;
        pend      = hold_full && tx_en;
        busy      = eng_active || hold_full;
    end

    tx_hold_buf #(.W(MAX_DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .accept_ok (accept_ok),
        .take      (load_fire),
        .full      (hold_full),
        .data      (hold_data)
    );

    tx_frame_engine #(.MAX_DATA_W(MAX_DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .pend       (pend),
        .word       (hold_data),
        .fmt_sel    (fmt_sel),
        .par_odd    (par_odd),
        .dbl_buf    (dbl_buf),
        .txd        (txd),
        .active     (eng_active),
        .load_fire  (load_fire),
        .stop_begin (stop_begin),
        .dbl_q      (eng_dbl)
    );

    tx_irq_ctl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_fire  (load_fire),
        .stop_begin (stop_begin),
        .dbl_now    (dbl_buf),
        .dbl_frame  (eng_dbl),
        .irq        (tx_irq)
    );

endmodule

// File: rtl/uart_dbuf_tx_chk.sv
// Module: property checker bound to the transmitter top.
// Assumes: a synchronous active-low reset.
module uart_dbuf_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic txd,
    input logic busy,
    input logic tx_irq,
    input logic eng_active,
    input logic eng_dbl
);

    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && !tx_irq));

    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_irq_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !eng_dbl) |-> txd);

    p_irq_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && eng_dbl) |-> !txd);

    p_no_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_active && !baud_tick) |=> eng_active);

    p_busy_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_active |-> busy);

endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .txd        (txd),
    .busy       (busy),
    .tx_irq     (tx_irq),
    .eng_active (eng_active),
    .eng_dbl    (eng_dbl)
);

// File: tb/uart_dbuf_tx_tb_top.sv
// Bench: scoreboard for the serial transmitter. The driver pushes expected
// frames; the monitor captures frames off the line and compares them.
module uart_dbuf_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b1;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic [2:0] fmt_sel = 3'd2;
    logic       par_odd = 1'b0;
    logic       dbl_buf = 1'b0;
    logic       txd;
    logic       busy;
    logic       tx_irq;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int seen = 0;
    bit done = 0;

    typedef struct {
        logic [11:0] bits;
        int          len;
        bit          dbl;
        bit          b2b;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    uart_dbuf_tx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .fmt_sel   (fmt_sel),
        .par_odd   (par_odd),
        .dbl_buf   (dbl_buf),
        .txd       (txd),
        .busy      (busy),
        .tx_irq    (tx_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected frame from the requirements (R2, R3, R4).
    function automatic item_t exp_frame(input logic [8:0] d, input logic [2:0] f,
                                        input logic odd, input bit dbl, input bit b2b);
        item_t it;
        int nd;
        bit pe;
        logic p;
        case (f)
            3'd0: begin nd = 7; pe = 0; end
            3'd1: begin nd = 7; pe = 1; end
            3'd3: begin nd = 8; pe = 1; end
            3'd4: begin nd = 9; pe = 0; end
            default: begin nd = 8; pe = 0; end
        endcase
        it.bits = '1;
        it.bits[0] = 1'b0;
        p = odd;
        for (int i = 0; i < nd; i++) begin
            it.bits[1+i] = d[i];
            p = p ^ d[i];
        end
        if (pe) it.bits[1+nd] = p;
        it.len = nd + (pe ? 1 : 0) + 2;
        it.dbl = dbl;
        it.b2b = b2b;
        return it;
    endfunction

    // Bit tick: one pulse every 8 clocks.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % 8;
            baud_tick = (c == 0);
        end
    end

    // Driver: one write strobe; push an expected frame if acceptance is predicted.
    task automatic do_write(input logic [8:0] d, input bit accept, input bit b2b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        if (accept) begin
            q.push_back(exp_frame(d, fmt_sel, par_odd, dbl_buf, b2b));
            pushed++;
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (20) @(negedge clk);
    endtask

    // Monitor: capture frames and compare with the scoreboard queue.
    initial begin
        logic  prev = 1'b1;
        int    gap = 100;
        item_t it;
        logic [11:0] got;
        forever begin
            @(negedge clk);
            gap++;
            if (rst_n && prev && !txd) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected frame", 32'd1, 32'd0);
                end else begin
                    it = q.pop_front();
                    seen++;
                    chk(tx_irq == it.dbl, it.dbl ? "R7" : "R6", "irq at start",
                        32'(tx_irq), 32'(it.dbl));
                    if (it.b2b) chk(gap == 4, "R8", "gap to next start", gap, 4);
                    got = '1;
                    for (int i = 0; i < it.len; i++) begin
                        if (i > 0) begin
                            repeat (4) @(negedge clk);
                            if (i == it.len - 1)
                                chk(tx_irq == !it.dbl, it.dbl ? "R7" : "R6",
                                    "irq at stop", 32'(tx_irq), 32'(!it.dbl));
                        end
                        repeat (4) @(negedge clk);
                        got[i] = txd;
                    end
                    for (int i = it.len; i < 12; i++) got[i] = 1'b1;
                    chk(got == it.bits, "R2", "frame bits", 32'(got), 32'(it.bits));
                    gap = 0;
                end
            end
            prev = txd;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd after reset", 32'(txd), 1);
        chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
        chk(tx_irq == 1'b0, "R1", "irq after reset", 32'(tx_irq), 0);

        // R3/R4: each format in single-buffer mode.
        fmt_sel = 3'd2; do_write(9'h0A5, 1, 0); wait_idle();
        fmt_sel = 3'd0; do_write(9'h1C3, 1, 0); wait_idle();
        fmt_sel = 3'd1; par_odd = 0; do_write(9'h055, 1, 0); wait_idle();
        fmt_sel = 3'd1; par_odd = 1; do_write(9'h013, 1, 0); wait_idle();
        fmt_sel = 3'd3; par_odd = 1; do_write(9'h0F0, 1, 0); wait_idle();
        fmt_sel = 3'd3; par_odd = 0; do_write(9'h001, 1, 0); wait_idle();
        fmt_sel = 3'd4; do_write(9'h1A5, 1, 0); wait_idle();
        fmt_sel = 3'd7; do_write(9'h13C, 1, 0); wait_idle();
        chk(txd == 1'b1 && busy == 1'b0, "R1", "idle after frames", {txd, busy}, 2'b10);

        // R9/R11: single-buffer write while busy is ignored.
        fmt_sel = 3'd2; par_odd = 0;
        do_write(9'h011, 1, 0);
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R11", "busy during frame", 32'(busy), 1);
        do_write(9'h022, 0, 0);
        wait_idle();
        chk(q.size() == 0, "R9", "pending after ignored write", q.size(), 0);

        // R8/R7/R9: double-buffer back to back, third write ignored.
        dbl_buf = 1'b1;
        do_write(9'h081, 1, 0);
        repeat (12) @(negedge clk);
        do_write(9'h042, 1, 1);
        do_write(9'h099, 0, 0);
        chk(busy == 1'b1, "R11", "busy with held word", 32'(busy), 1);
        wait_idle();
        chk(q.size() == 0, "R9", "double mode pending", q.size(), 0);

        // R5: format change mid-frame does not affect the frame.
        dbl_buf = 1'b0; fmt_sel = 3'd3; par_odd = 0;
        do_write(9'h00F, 1, 0);
        repeat (20) @(negedge clk);
        fmt_sel = 3'd4; par_odd = 1; dbl_buf = 1'b1;
        wait_idle();
        dbl_buf = 1'b0; fmt_sel = 3'd2; par_odd = 0;

        // R10: held word waits for enable; dropping enable mid-frame is harmless.
        tx_en = 1'b0;
        do_write(9'h05A, 1, 0);
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R10", "line idle while disabled", 32'(txd), 1);
        chk(busy == 1'b1, "R11", "busy while word held", 32'(busy), 1);
        chk(q.size() == 1, "R10", "no frame while disabled", q.size(), 1);
        tx_en = 1'b1;
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        wait_idle();
        tx_en = 1'b1;

        chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
        chk(seen == pushed, "R9", "frames seen", seen, pushed);
        chk(busy == 1'b0 && txd == 1'b1, "R1", "final idle", {busy, txd}, 2'b01);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule